// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a register-level management controller for an Ethernet PHY, carrying its own behavioural model of a single PHY register file so that it can be exercised without an external device. Software programs a write-data register, then writes a command word that names a PHY address, a PHY register, an opcode and an initiate flag. A write opcode copies the low 16 bits of the write-data register into the addressed PHY register; a read opcode captures the PHY register into the read-data register, where software fetches it with a normal bus read. The serial MDC/MDIO bit timing is not modelled: each transaction completes in the clock edge at which the command is written, so the engine always reports itself ready.

The PHY model answers one configurable address. Most of its 32 registers are plain 16-bit storage, but the basic status, link-partner ability, speed/duplex diagnostic and extended speed registers are computed from the link input and the advertised abilities. Every write into the model clears the self-clearing reset and restart-negotiation bits of the control register. The bus side is four 32-bit registers selected by a 2-bit address; reads return data one cycle after the request with a valid strobe and accept no back-pressure.

Top module: `mdio_cmd_engine`

## Requirements
- R1: The command word carries PHY address in bits 28:24, PHY register in bits 20:16, opcode in bits 15:14 and initiate in bit 11; initiate with opcode 1 stores bits 15:0 of the write-data register into the addressed PHY register.
- R2: Initiate with opcode 2 loads the read-data register with the addressed PHY register, zero-extended to 32 bits.
- R3: When the command's PHY address differs from the model's address (default 7), a read returns 0xFFFF and a write changes no PHY register.
- R4: Reading the command register returns the last written command with bit 7 forced to 1.
- R5: Initiate with opcode 0 or 3 raises cmd_bad_op for exactly one cycle and changes neither the PHY nor the read-data register; a command without initiate does nothing.
- R6: The config register keeps only bits 6:0 (reads zero above); cfg_error is 1 while bit 6 is set and bits 5:0 are zero.
- R7: After reset the PHY reads 0x3100 at register 0, 0x0300 at 2, 0xE400 at 3 and 0x01E1 at 4.
- R8: After any PHY write, register 0 has bits 15 and 9 cleared (data written there is stored masked with ~0x8200).
- R9: Register 1 reads 0x782E while phy_link_up is 1 and 0x0000 while it is 0.
- R10: Register 5 reads 0x4001 plus bits 8:5 of register 4.
- R11: Register 18 reads bit 10 set when register 4 has 0x0080 or 0x0100 set, bit 11 set when it has 0x0100 or 0x0040 set, other bits zero; 0 while the link is down.
- R12: Register 17 always reads 0x8000.
- R13: Bus offsets are 0 config, 1 command, 2 write data, 3 read data; a read request yields bus_rd_valid and data exactly one cycle later, and all bus registers are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read request |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rd_valid | output | 1 | Read data valid, one cycle after request |
| bus_rdata | output | 32 | Read data |
| phy_link_up | input | 1 | Link state of the modelled PHY |
| cfg_error | output | 1 | Interface enabled with a zero clock divider |
| cmd_bad_op | output | 1 | One-cycle pulse on an initiated unknown opcode |

## Verification
The PHY model is read at every reset value and every synthesized register, so stored and computed paths are told apart. Advertisement patterns with only 10-full, only 100-half, and the reset mix separate the speed and duplex terms of the diagnostic register, while toggling the link input isolates the link-gated registers. Writes to the control register with the self-clearing bits set, writes to a foreign PHY address, and unknown or un-initiated opcodes each show whether state changes that must not.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int BUS_DW   = 32;
  localparam int BUS_AW   = 2;
  localparam int PHY_DW   = 16;
  localparam int REG_AW   = 5;
  localparam int NUM_REGS = 1 << REG_AW;
  localparam int CFG_W    = 7;

  localparam logic [BUS_AW-1:0] SEL_CFG  = 2'd0;
  localparam logic [BUS_AW-1:0] SEL_CMD  = 2'd1;
  localparam logic [BUS_AW-1:0] SEL_WDAT = 2'd2;
  localparam logic [BUS_AW-1:0] SEL_RDAT = 2'd3;

  localparam logic [1:0] OPC_WRITE = 2'd1;
  localparam logic [1:0] OPC_READ  = 2'd2;

  localparam logic [PHY_DW-1:0] CTRL_SELFCLR = 16'h8200;

  typedef struct packed {
    logic [REG_AW-1:0] phy;
    logic [REG_AW-1:0] regn;
    logic [1:0]        op;
    logic              go;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_cmd_decode.sv
module mdio_cmd_decode
  import mdio_mgmt_pkg::*;
(
  input  logic [BUS_DW-1:0] cmd_word,
  input  logic              cmd_strobe,
  output mdio_cmd_t         cmd,
  output logic              do_write,
  output logic              do_read,
  output logic              bad_op
);
  always_comb begin
    cmd.phy  = cmd_word[28:24];
    cmd.regn = cmd_word[20:16];
    cmd.op   = cmd_word[15:14];
    cmd.go   = cmd_word[11];
    do_write = cmd_strobe && cmd.go && (cmd.op == OPC_WRITE);
    do_read  = cmd_strobe && cmd.go && (cmd.op == OPC_READ);
    bad_op   = cmd_strobe && cmd.go && !(cmd.op == OPC_WRITE) && !(cmd.op == OPC_READ);
  end
endmodule

// File: rtl/mdio_phy_status.sv
module mdio_phy_status
  import mdio_mgmt_pkg::*;
(
  input  logic              link_up,
  input  logic [PHY_DW-1:0] adv,
  output logic [PHY_DW-1:0] bsr,
  output logic [PHY_DW-1:0] partner,
  output logic [PHY_DW-1:0] ext_speed,
  output logic [PHY_DW-1:0] diag
);
  logic fast, full;

  always_comb begin
    fast      = adv[7] | adv[8];
    full      = adv[8] | adv[6];
    bsr       = link_up ? 16'h782E : '0;
    partner   = 16'h4001 | (adv & 16'h01E0);
    ext_speed = 16'h8000;
    diag      = '0;
    if (link_up) begin
      diag[10] = fast;
      diag[11] = full;
    end
  end
endmodule

// File: rtl/mdio_phy_model.sv
module mdio_phy_model
  import mdio_mgmt_pkg::*;
#(
  parameter logic [REG_AW-1:0] PHY_ADDR = 5'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] phy_sel,
  input  logic [REG_AW-1:0] reg_sel,
  input  logic [PHY_DW-1:0] wdata,
  output logic [PHY_DW-1:0] rdata
);
  logic [PHY_DW-1:0] store [NUM_REGS];
  logic [PHY_DW-1:0] bsr, partner, ext_speed, diag;
  logic              hit;

  assign hit = (phy_sel == PHY_ADDR);

  function automatic logic [PHY_DW-1:0] rst_val(input int idx);
    case (idx)
      0:       rst_val = 16'h3100;
      2:       rst_val = 16'h0300;
      3:       rst_val = 16'hE400;
      4:       rst_val = 16'h01E1;
      default: rst_val = '0;
    endcase
  endfunction

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [PHY_DW-1:0] nxt;
    always_comb begin
      nxt = (hit && reg_sel == REG_AW'(i)) ? wdata : store[i];
      if (i == 0) nxt = nxt & ~CTRL_SELFCLR;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)     store[i] <= rst_val(i);
      else if (wr_en && hit) store[i] <= nxt;
    end
  end

  mdio_phy_status status_i (
    .link_up   (link_up),
    .adv       (store[4]),
    .bsr       (bsr),
    .partner   (partner),
    .ext_speed (ext_speed),
    .diag      (diag)
  );

  always_comb begin
    if (!hit) rdata = 16'hFFFF;
    else begin
      case (reg_sel)
        5'd1:    rdata = bsr;
        5'd5:    rdata = partner;
        5'd17:   rdata = ext_speed;
        5'd18:   rdata = diag;
        default: rdata = store[reg_sel];
      endcase
    end
  end
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_mgmt_pkg::*;
#(
  parameter logic [REG_AW-1:0] PHY_ADDR = 5'd7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic              bus_rd_valid,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic              phy_link_up,
  output logic              cfg_error,
  output logic              cmd_bad_op
);
  logic [CFG_W-1:0]  cfg_q;
  logic [BUS_DW-1:0] cmd_q, wdat_q, rdat_q;
  logic [PHY_DW-1:0] phy_rdata;
  mdio_cmd_t         cmd;
  logic              do_write, do_read, bad_op, cmd_strobe;

  assign cmd_strobe = bus_wr_en && (bus_addr == SEL_CMD);

  mdio_cmd_decode decode_i (
    .cmd_word   (bus_wdata),
    .cmd_strobe (cmd_strobe),
    .cmd        (cmd),
    .do_write   (do_write),
    .do_read    (do_read),
    .bad_op     (bad_op)
  );

  mdio_phy_model #(.PHY_ADDR(PHY_ADDR)) phy_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .link_up (phy_link_up),
    .wr_en   (do_write),
    .phy_sel (cmd.phy),
    .reg_sel (cmd.regn),
    .wdata   (wdat_q[PHY_DW-1:0]),
    .rdata   (phy_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      cmd_q      <= '0;
      wdat_q     <= '0;
      rdat_q     <= '0;
      cmd_bad_op <= 1'b0;
    end else begin
      cmd_bad_op <= bad_op;
      if (bus_wr_en) begin
        case (bus_addr)
          SEL_CFG:  cfg_q  <= bus_wdata[CFG_W-1:0];
          SEL_CMD:  cmd_q  <= bus_wdata;
          SEL_WDAT: wdat_q <= bus_wdata;
          default:  rdat_q <= bus_wdata;
        endcase
      end
      if (do_read) rdat_q <= {{(BUS_DW-PHY_DW){1'b0}}, phy_rdata};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rd_valid <= 1'b0;
      bus_rdata    <= '0;
    end else begin
      bus_rd_valid <= bus_rd_en;
      if (bus_rd_en) begin
        case (bus_addr)
          SEL_CFG:  bus_rdata <= {{(BUS_DW-CFG_W){1'b0}}, cfg_q};
          SEL_CMD:  bus_rdata <= cmd_q | 32'h0000_0080;
          SEL_WDAT: bus_rdata <= wdat_q;
          default:  bus_rdata <= rdat_q;
        endcase
      end
    end
  end

  assign cfg_error = cfg_q[6] && (cfg_q[5:0] == '0);
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr_en,
  input logic        bus_rd_en,
  input logic [1:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_rd_valid,
  input logic [31:0] bus_rdata,
  input logic        cfg_error,
  input logic        cmd_bad_op
);
  // R13
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |=> bus_rd_valid);

  // R4
  cmd_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_addr == 2'd1) |=> bus_rdata[7]);

  // R5
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == 2'd1 && bus_wdata[11] &&
     (bus_wdata[15:14] == 2'd0 || bus_wdata[15:14] == 2'd3)) |=> cmd_bad_op);

  // R6
  cfg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == 2'd0 && bus_wdata[6] && bus_wdata[5:0] == 6'd0)
      |=> cfg_error);

  // R6
  cfg_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_addr == 2'd0) |=> (bus_rdata[31:7] == '0));
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr_en    (bus_wr_en),
  .bus_rd_en    (bus_rd_en),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rd_valid (bus_rd_valid),
  .bus_rdata    (bus_rdata),
  .cfg_error    (cfg_error),
  .cmd_bad_op   (cmd_bad_op)
);

// File: tb/mdio_cmd_engine_tb_top.sv
module mdio_cmd_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd_valid;
  logic [31:0] bus_rdata;
  logic        phy_link_up = 1'b1;
  logic        cfg_error;
  logic        cmd_bad_op;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mdio_cmd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd_valid(bus_rd_valid),
    .bus_rdata(bus_rdata), .phy_link_up(phy_link_up), .cfg_error(cfg_error),
    .cmd_bad_op(cmd_bad_op)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every returned read
  always @(negedge clk) begin
    if (rst_n && bus_rd_valid) begin
      if (exp_q.size() == 0) check("R13 unexpected read", 32'h1, 32'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  function automatic logic [31:0] cmd(input logic [4:0] phy, input logic [4:0] r,
                                      input logic [1:0] op, input logic go);
    cmd = {3'b0, phy, 3'b0, r, op, 2'b0, go, 11'b0};
  endfunction

  task automatic phy_read(input logic [4:0] phy, input logic [4:0] r,
                          input logic [15:0] exp, input string tag);
    bus_wr(2'd1, cmd(phy, r, 2'd2, 1'b1));
    bus_rd(2'd3, {16'h0, exp}, tag);
  endtask

  task automatic phy_write(input logic [4:0] phy, input logic [4:0] r, input logic [15:0] d);
    bus_wr(2'd2, {16'h0, d});
    bus_wr(2'd1, cmd(phy, r, 2'd1, 1'b1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset cfg_error", {31'b0, cfg_error}, 32'h0);
    check("R5 reset bad_op", {31'b0, cmd_bad_op}, 32'h0);
    bus_rd(2'd3, 32'h0, "R13 reset read-data");
    bus_rd(2'd2, 32'h0, "R13 reset write-data");
    bus_rd(2'd1, 32'h80, "R4 reset command ready bit");

    phy_read(5'd7, 5'd0, 16'h3100, "R7 reg0 reset");
    phy_read(5'd7, 5'd2, 16'h0300, "R7 reg2 reset");
    phy_read(5'd7, 5'd3, 16'hE400, "R2 R7 reg3 reset");
    phy_read(5'd7, 5'd4, 16'h01E1, "R7 reg4 reset");
    phy_read(5'd7, 5'd1, 16'h782E, "R9 link up");
    phy_read(5'd7, 5'd5, 16'h41E1, "R10 default adv");
    phy_read(5'd7, 5'd17, 16'h8000, "R12 reg17");
    phy_read(5'd7, 5'd18, 16'h0C00, "R11 default adv");
    phy_read(5'd3, 5'd0, 16'hFFFF, "R3 foreign read");

    phy_write(5'd7, 5'd4, 16'h0041);
    phy_read(5'd7, 5'd5, 16'h4041, "R10 10-full only");
    phy_read(5'd7, 5'd18, 16'h0800, "R11 10-full only");
    phy_write(5'd7, 5'd4, 16'h0081);
    phy_read(5'd7, 5'd18, 16'h0400, "R11 100-half only");

    phy_write(5'd7, 5'd0, 16'hB340);
    phy_read(5'd7, 5'd0, 16'h3140, "R8 self-clear bits");
    phy_write(5'd7, 5'd20, 16'hABCD);
    phy_read(5'd7, 5'd20, 16'hABCD, "R1 plain storage");
    phy_write(5'd5, 5'd20, 16'h1111);
    phy_read(5'd7, 5'd20, 16'hABCD, "R3 foreign write ignored");

    // R5: unknown opcodes and missing initiate leave read-data alone
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 2'd1; bus_wdata = cmd(5'd7, 5'd2, 2'd0, 1'b1);
    @(negedge clk);
    bus_wr_en = 1'b0;
    check("R5 bad_op pulse", {31'b0, cmd_bad_op}, 32'h1);
    @(negedge clk);
    check("R5 bad_op one cycle", {31'b0, cmd_bad_op}, 32'h0);
    bus_wr(2'd1, cmd(5'd7, 5'd2, 2'd3, 1'b1));
    bus_wr(2'd1, cmd(5'd7, 5'd2, 2'd2, 1'b0));
    bus_rd(2'd3, 32'h0000_ABCD, "R5 read-data unchanged");

    phy_link_up = 1'b0;
    phy_read(5'd7, 5'd1, 16'h0000, "R9 link down");
    phy_read(5'd7, 5'd18, 16'h0000, "R11 link down");
    phy_link_up = 1'b1;

    bus_wr(2'd0, 32'hFFFF_FFC0);
    bus_rd(2'd0, 32'h40, "R6 config width");
    check("R6 cfg_error set", {31'b0, cfg_error}, 32'h1);
    bus_wr(2'd0, 32'h41);
    check("R6 cfg_error clear", {31'b0, cfg_error}, 32'h0);
    bus_wr(2'd1, 32'h0705_0000);
    bus_rd(2'd1, 32'h0705_0080, "R4 command readback");

    repeat (3) @(negedge clk);
    check("R13 scoreboard drained", exp_q.size(), 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule